// File: doc/BRIEF.md
# Fine-Grained Function-Unit Fault Monitor

This block watches the fault sensors placed inside each function unit of a multi-issue execute stage. Every function unit is split into nine small components: component 0 is the result-select multiplexer and components 1 to 8 are operation groups. A unit with a multiplier has all nine. A unit without one lacks component 5. The monitor presents the live per-component fault status of all issues. It flags any component whose fault has just appeared relative to the previous cycle. It also decides, for each issue, whether the result now leaving the execute stage touched a faulty component.

A scheduler upstream uses the status and the new-fault flag to move work onto healthy components. The write-back path uses the squash vector to replace a tainted result with a NOP and to turn off that issue's memory and register-write enables. The squash decision is combinational, so it acts in the same cycle as the instruction it judges. The only state in the block is a register that holds the previous cycle's status.

Top module: `fu_fault_monitor`

## Requirements
- R1: `status_o` carries each sensor bit unchanged, except component 5 of an issue configured as simple, which always reads 0.
- R2: `new_fault_o` is high in a cycle exactly when some bit of `status_o` is 1 in that cycle and was 0 in the previous clocked cycle.
- R3: Reset clears the stored previous status to all zeros. With quiet sensors, no new fault is reported after reset. A fault that is already present in the first cycle after reset is reported as new.
- R4: A fault that persists unchanged does not raise `new_fault_o` again, and a fault that clears does not raise it.
- R5: `squash_o[i]` is 1 when issue i is valid and its required-component mask, with component 0 always added, overlaps that issue's status. Otherwise it is 0.
- R6: A fault on component 0 of an issue squashes any valid instruction on that issue, even when its mask is all zeros.
- R7: An issue whose `ex_valid` bit is 0 is never squashed, whatever the faults.
- R8: On a simple issue, the component-5 sensor bit and a component-5 request have no effect on `status_o`, `new_fault_o` or `squash_o`.
- R9: Faults on one issue never squash another issue.
- R10: Bit layout: component c of issue i sits at bit 9*i+c of `sense_i`, `ex_need_i` and `status_o`, with issue i at bit i of `ex_valid_i` and `squash_o`. Components are numbered 0 select, 1 add/address/add-shift, 2 and/nand/zero-extend, 3 or/nor/xor, 4 compare/subtract, 5 multiply, 6 logical right shift, 7 arithmetic right shift, 8 left shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sense_i | input | NUM_ISSUE*9 | Per-component fault sensor outputs, all issues |
| ex_valid_i | input | NUM_ISSUE | Execute stage holds a valid instruction on the issue |
| ex_need_i | input | NUM_ISSUE*9 | Components required by each executing instruction |
| status_o | output | NUM_ISSUE*9 | Current per-component fault status |
| new_fault_o | output | 1 | Some component fault appeared since the previous cycle |
| squash_o | output | NUM_ISSUE | Replace the issue's result with a NOP and block its memory and write-back |

## Verification
New-fault detection and squashing can both occur in the same cycle. This happens when a sensor bit rises under a valid instruction that needs that component. The bench drives this case and expects `new_fault_o` and the squash bit to be high together. In the following cycle, with the fault held, it expects the squash to stay and the new-fault flag to drop. Once the fault clears, it expects both to read low.

// File: rtl/fuf_pkg.sv
package fuf_pkg;

    localparam int unsigned COMP_W = 9;

    typedef enum logic [3:0] {
        CMP_SEL   = 4'd0,
        CMP_ADD   = 4'd1,
        CMP_ANDX  = 4'd2,
        CMP_ORX   = 4'd3,
        CMP_SUB   = 4'd4,
        CMP_MUL   = 4'd5,
        CMP_SHR   = 4'd6,
        CMP_SAR   = 4'd7,
        CMP_SHL   = 4'd8
    } comp_id_e;

    function automatic logic [COMP_W-1:0] comp_bit(comp_id_e c);
        logic [COMP_W-1:0] m;
        m = '0;
        m[c] = 1'b1;
        return m;
    endfunction

    // Components physically present in a unit of the given kind.
    function automatic logic [COMP_W-1:0] present_mask(bit is_complex);
        logic [COMP_W-1:0] m;
        m = '1;
        if (!is_complex) m[CMP_MUL] = 1'b0;
        return m;
    endfunction

endpackage

// File: rtl/fuf_slot.sv
module fuf_slot
    import fuf_pkg::*;
#(
    parameter bit IS_COMPLEX = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COMP_W-1:0] sense_i,
    input  logic              valid_i,
    input  logic [COMP_W-1:0] need_i,
    output logic [COMP_W-1:0] status_o,
    output logic              squash_o
);

    localparam logic [COMP_W-1:0] PRESENT = present_mask(IS_COMPLEX);
    localparam logic [COMP_W-1:0] SEL_BIT = comp_bit(CMP_SEL);

    logic [COMP_W-1:0] need_full;

    always_comb begin
        status_o  = sense_i & PRESENT;
        need_full = need_i | SEL_BIT;
        squash_o  = valid_i && (|(need_full & status_o));
    end

    assert_squash_needs_valid_R7: assert property (
        @(posedge clk) disable iff (!rst_n) squash_o |-> valid_i);

    assert_sel_fault_squash_R6: assert property (
        @(posedge clk) disable iff (!rst_n) (valid_i && sense_i[CMP_SEL]) |-> squash_o);

    generate
        if (!IS_COMPLEX) begin : g_simple
            assert_no_mul_status_R8: assert property (
                @(posedge clk) disable iff (!rst_n) !status_o[CMP_MUL]);
        end
    endgenerate

endmodule

// File: rtl/fuf_rise_detect.sv
module fuf_rise_detect #(
    parameter int unsigned W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur_i,
    output logic         rise_o
);

    typedef struct packed {
        logic [W-1:0] prev;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = cur_i;
        rise_o    = |(cur_i & ~st_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_rise_reported_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (armed_q && (|(cur_i & ~$past(cur_i)))) |-> rise_o);

    assert_steady_no_rise_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (armed_q && $stable(cur_i)) |-> !rise_o);

endmodule

// File: rtl/fu_fault_monitor.sv
module fu_fault_monitor
    import fuf_pkg::*;
#(
    parameter int unsigned          NUM_ISSUE     = 4,
    parameter logic [NUM_ISSUE-1:0] ISSUE_COMPLEX = 4'b0011
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_ISSUE*COMP_W-1:0]   sense_i,
    input  logic [NUM_ISSUE-1:0]          ex_valid_i,
    input  logic [NUM_ISSUE*COMP_W-1:0]   ex_need_i,
    output logic [NUM_ISSUE*COMP_W-1:0]   status_o,
    output logic                          new_fault_o,
    output logic [NUM_ISSUE-1:0]          squash_o
);

    localparam int unsigned VEC_W = NUM_ISSUE * COMP_W;

    logic [VEC_W-1:0] status_w;

    generate
        for (genvar i = 0; i < NUM_ISSUE; i++) begin : g_issue
            fuf_slot #(
                .IS_COMPLEX (ISSUE_COMPLEX[i])
            ) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .sense_i  (sense_i[i*COMP_W +: COMP_W]),
                .valid_i  (ex_valid_i[i]),
                .need_i   (ex_need_i[i*COMP_W +: COMP_W]),
                .status_o (status_w[i*COMP_W +: COMP_W]),
                .squash_o (squash_o[i])
            );

            assert_squash_has_fault_R5: assert property (
                @(posedge clk) disable iff (!rst_n)
                squash_o[i] |-> (|status_o[i*COMP_W +: COMP_W]));
        end
    endgenerate

    fuf_rise_detect #(
        .W (VEC_W)
    ) u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .cur_i  (status_w),
        .rise_o (new_fault_o)
    );

    assign status_o = status_w;

endmodule

// File: tb/sim_fu_fault_monitor.sv
`timescale 1ns/1ps
module sim_fu_fault_monitor;
    import fuf_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [35:0] sense = '0;
    logic [3:0]  valid = '0;
    logic [35:0] need = '0;
    logic [35:0] status;
    logic        newf;
    logic [3:0]  squash;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fu_fault_monitor #(.NUM_ISSUE(4), .ISSUE_COMPLEX(4'b0011)) u0 (
        .clk(clk), .rst_n(rst_n), .sense_i(sense), .ex_valid_i(valid),
        .ex_need_i(need), .status_o(status), .new_fault_o(newf), .squash_o(squash)
    );

    function automatic logic [35:0] at(int i, logic [8:0] m);
        return {27'b0, m} << (9 * i);
    endfunction

    task automatic chk(string tag, logic [35:0] got, logic [35:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Apply inputs after a falling edge; outputs settle before the next rising edge.
    task automatic drive(logic [35:0] s, logic [3:0] v, logic [35:0] n);
        @(negedge clk);
        sense = s; valid = v; need = n;
        #1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        drive('0, '0, '0);
        drive('0, '0, '0);
        rst_n = 1'b1;
        drive('0, '0, '0);
        chk("R3 status after reset", status, '0);
        chk("R3 no new fault after reset", {35'b0, newf}, 36'd0);
        chk("R3 no squash after reset", {32'b0, squash}, 36'd0);
    endtask

    task automatic t_reset_with_fault;
        @(negedge clk);
        rst_n = 1'b0;
        sense = at(1, comp_bit(CMP_ORX));
        valid = '0; need = '0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R3 fault present at reset exit is new", {35'b0, newf}, 36'd1);
        drive(at(1, comp_bit(CMP_ORX)), '0, '0);
        chk("R3 held fault not new again", {35'b0, newf}, 36'd0);
    endtask

    task automatic t_status_map;
        drive('0, '0, '0);
        drive(at(0, 9'h0F0) | at(2, 9'h1FF) | at(3, 9'h020), '0, '0);
        chk("R1 R10 status map", status, at(0, 9'h0F0) | at(2, 9'h1DF));
        chk("R2 rise from zero", {35'b0, newf}, 36'd1);
    endtask

    task automatic t_new_fault;
        drive(at(0, 9'h0F0) | at(2, 9'h1FF), '0, '0);
        chk("R4 persisting fault", {35'b0, newf}, 36'd0);
        drive(at(0, 9'h0E0) | at(2, 9'h1FF), '0, '0);
        chk("R4 clearing fault", {35'b0, newf}, 36'd0);
        drive(at(0, 9'h0E0) | at(2, 9'h1FF) | at(1, 9'h004), '0, '0);
        chk("R2 added fault", {35'b0, newf}, 36'd1);
        drive(at(0, 9'h0E0) | at(2, 9'h1FF) | at(1, 9'h004) | at(3, 9'h020), '0, '0);
        chk("R8 simple mul sensor not new", {35'b0, newf}, 36'd0);
    endtask

    task automatic t_squash;
        drive('0, '0, '0);
        drive(at(0, comp_bit(CMP_SHL)), 4'b1111,
              at(0, comp_bit(CMP_SHL)) | at(1, comp_bit(CMP_SHL)) |
              at(2, comp_bit(CMP_ADD)) | at(3, comp_bit(CMP_ADD)));
        chk("R5 overlap squashes issue 0", {32'b0, squash}, 36'h1);
        drive(at(0, comp_bit(CMP_SHL)), 4'b1111, at(0, comp_bit(CMP_SAR)));
        chk("R5 no overlap no squash", {32'b0, squash}, 36'h0);
    endtask

    task automatic t_sel;
        drive(at(2, comp_bit(CMP_SEL)), 4'b1111, '0);
        chk("R6 select fault squashes empty mask", {32'b0, squash}, 36'h4);
    endtask

    task automatic t_invalid;
        drive('1, 4'b0000, '1);
        chk("R7 invalid never squashed", {32'b0, squash}, 36'h0);
        drive('1, 4'b1010, '1);
        chk("R7 only valid issues squashed", {32'b0, squash}, 36'hA);
    endtask

    task automatic t_simple_mul;
        drive('0, '0, '0);
        drive(at(3, comp_bit(CMP_MUL)), 4'b1000, at(3, comp_bit(CMP_MUL)));
        chk("R8 simple mul squash", {32'b0, squash}, 36'h0);
        chk("R8 simple mul status", status, '0);
        chk("R8 simple mul new fault", {35'b0, newf}, 36'd0);
        drive(at(1, comp_bit(CMP_MUL)), 4'b0010, at(1, comp_bit(CMP_MUL)));
        chk("R5 complex mul squash", {32'b0, squash}, 36'h2);
    endtask

    task automatic t_isolation;
        drive(at(1, 9'h1FF), 4'b1111, at(0, 9'h1FE) | at(1, 9'h1FE) | at(2, 9'h1FE) | at(3, 9'h1FE));
        chk("R9 only faulty issue squashed", {32'b0, squash}, 36'h2);
    endtask

    task automatic t_same_cycle;
        drive('0, '0, '0);
        drive(at(0, comp_bit(CMP_SUB)), 4'b0001, at(0, comp_bit(CMP_SUB)));
        chk("R2 new fault same cycle", {35'b0, newf}, 36'd1);
        chk("R5 squash same cycle", {32'b0, squash}, 36'h1);
        drive(at(0, comp_bit(CMP_SUB)), 4'b0001, at(0, comp_bit(CMP_SUB)));
        chk("R4 held fault not new", {35'b0, newf}, 36'd0);
        chk("R5 held fault still squashes", {32'b0, squash}, 36'h1);
        drive('0, 4'b0001, at(0, comp_bit(CMP_SUB)));
        chk("R4 cleared fault not new", {35'b0, newf}, 36'd0);
        chk("R5 cleared fault no squash", {32'b0, squash}, 36'h0);
    endtask

    initial begin
        t_reset();
        t_status_map();
        t_new_fault();
        t_squash();
        t_sel();
        t_invalid();
        t_simple_mul();
        t_isolation();
        t_same_cycle();
        t_reset_with_fault();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule